// File: doc/BRIEF.md
# Three-Wire Synthesizer Programming Sequencer

This block loads an external frequency synthesizer over a three-line serial link: a data line, a shift clock and a latch strobe. Two stored words of 24 bits each are sent one after the other. Each word goes out most significant bit first and is followed by a latch pulse that moves it into the synthesizer's divider registers. A word shorter than 24 bits is padded at its leading end. The padding is clocked out like any other bit, so only the trailing bits are kept by the synthesizer.

A transfer starts when the device's power state goes from off to on, and only while the enable configuration input is set. The link is slowed to suit the receive bit rate. Inside the thirteenth bit of each word the shift clock stays low for an extra pause, and the same pause is added to the gap between the two words. A busy flag and an oscillator-enable output are held high for the whole transfer.

Top module: `synth_loader`

## Requirements
- R1: After reset, ser_clk, ser_data, ser_latch, busy and osc_en are all low.
- R2: A rising edge on power_on, sampled while cfg_enable is 1 and the block is idle, starts a transfer. busy is high in the cycle after the clock edge that samples power_on high.
- R3: When cfg_enable is 0, a rising edge on power_on starts nothing: busy, ser_clk and ser_latch stay low.
- R4: A transfer sends 48 bits on ser_data in this order: blk_a bit 23 down to bit 0, then blk_b bit 23 down to bit 0. Each bit is taken when ser_clk rises, and leading padding bits are sent as well.
- R5: ser_data changes only while ser_clk is low. Outside the pauses, each bit has ser_clk low for HALF cycles and then high for HALF cycles.
- R6: After the 24th bit of each word, ser_clk stays low for HALF cycles and then ser_latch is high for 2*HALF cycles. This gives exactly two latch pulses per transfer, and ser_clk is low whenever ser_latch is high.
- R7: The low phase of the 13th bit of each word (bit index 12, counting the first bit sent as 0) lasts HALF+tp cycles. tp depends on rate_sel: code 0 gives 119, code 1 gives 33, and codes 2 and 3 give 1.
- R8: From the end of the first latch pulse to the first ser_clk rise of the second word, ser_clk is low for 2*HALF+tp cycles.
- R9: busy and osc_en are high together for exactly 103*HALF+3*tp consecutive cycles, and fall when the second latch pulse ends.
- R10: A new rising edge on power_on during a transfer is ignored. If power_on stays high after a transfer, no new transfer starts.
- R11: blk_a, blk_b and rate_sel are captured at the start. Changing them during a transfer does not change the bits that are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| power_on | input | 1 | Device power state, 1 = on |
| cfg_enable | input | 1 | Configuration bit that enables synthesizer loading |
| rate_sel | input | 2 | Receive bit-rate code (0: 512, 1: 1200, 2/3: 2400 bit/s) |
| blk_a | input | 24 | First word to send |
| blk_b | input | 24 | Second word to send |
| ser_data | output | 1 | Serial data to the synthesizer |
| ser_clk | output | 1 | Serial shift clock, idles low |
| ser_latch | output | 1 | Latch strobe, idles low |
| busy | output | 1 | Transfer in progress |
| osc_en | output | 1 | Oscillator/synthesizer enable during a transfer |

## Verification
busy first appears one cycle after the edge that samples the power-on rising edge. The bench therefore checks busy on the falling edge just before that edge and on the falling edge just after it. All serial results come out of one phase counter and go straight to the pins with no further register. A monitor samples the pins on every falling clock edge and measures run lengths in whole cycles, so each low, high, latch and busy duration is compared with the arithmetic expectations HALF, HALF+tp, 2*HALF+tp, 2*HALF and 103*HALF+3*tp. Twenty idle cycles after each transfer confirm that neither a held nor a repeated power-on edge starts a second one.

// File: rtl/synth_loader_pkg.sv
package synth_loader_pkg;

    localparam int BLK_W     = 24;
    localparam int PAUSE_IDX = 12;
    localparam int TP_MAX    = 119;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LOW,
        PH_HIGH,
        PH_SETTLE,
        PH_LATCH,
        PH_GAP
    } phase_e;

    typedef enum logic [1:0] {
        RATE_512  = 2'd0,
        RATE_1200 = 2'd1,
        RATE_2400 = 2'd2,
        RATE_ALT  = 2'd3
    } rate_e;

    // Extra low time, in clocks, added to bit 13 and to the inter-word gap
    function automatic logic [7:0] pause_cycles(input logic [1:0] code);
        case (rate_e'(code))
            RATE_512:  return 8'd119;
            RATE_1200: return 8'd33;
            default:   return 8'd1;
        endcase
    endfunction

endpackage

// File: rtl/sl_phase_timer.sv
module sl_phase_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expire
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expire = (cnt == '0);

endmodule

// File: rtl/sl_block_shifter.sv
module sl_block_shifter #(
    parameter int BW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic          shift,
    input  logic [BW-1:0] blk_a,
    input  logic [BW-1:0] blk_b,
    output logic          bit_out
);
    localparam int SW = 2 * BW;

    logic [SW-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst)
            sr <= '0;
        else if (capture)
            sr <= {blk_a, blk_b};
        else if (shift)
            sr <= {sr[SW-2:0], 1'b0};
    end

    assign bit_out = sr[SW-1];

    // R11: stored words move only on capture or shift
    a_r11_hold_between_steps: assert property (@(posedge clk) disable iff (rst)
        (!capture && !shift) |=> $stable(bit_out));

endmodule

// File: rtl/sl_seq_ctrl.sv
module sl_seq_ctrl
    import synth_loader_pkg::*;
#(
    parameter int BW   = 24,
    parameter int PIDX = 12,
    parameter int HALF = 2,
    parameter int CW   = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          trigger,
    input  logic [1:0]    rate,
    input  logic          expire,
    output logic          capture,
    output logic          shift,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output phase_e        phase
);
    localparam int IW = (BW > 1) ? $clog2(BW) : 1;
    localparam logic [CW-1:0] HALF_M1 = CW'(HALF - 1);
    localparam logic [CW-1:0] FULL_M1 = CW'(2 * HALF - 1);
    localparam logic [IW-1:0] LAST_IDX  = IW'(BW - 1);
    localparam logic [IW-1:0] PAUSE_AT  = IW'(PIDX);

    phase_e        ph_n;
    logic [IW-1:0] bit_idx, idx_n;
    logic          blk2, blk2_n;
    logic [1:0]    rate_q, rate_n;
    logic [CW-1:0] tp_w;

    assign tp_w = CW'(pause_cycles(rate_q));

    always_comb begin
        ph_n     = phase;
        idx_n    = bit_idx;
        blk2_n   = blk2;
        rate_n   = rate_q;
        capture  = 1'b0;
        shift    = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (phase)
            PH_IDLE: if (trigger) begin
                ph_n     = PH_LOW;
                idx_n    = '0;
                blk2_n   = 1'b0;
                rate_n   = rate;
                capture  = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = HALF_M1;
            end
            PH_LOW: if (expire) begin
                ph_n     = PH_HIGH;
                tmr_load = 1'b1;
                tmr_val  = HALF_M1;
            end
            PH_HIGH: if (expire) begin
                tmr_load = 1'b1;
                if (bit_idx == LAST_IDX) begin
                    ph_n    = PH_SETTLE;
                    tmr_val = HALF_M1;
                end else begin
                    ph_n    = PH_LOW;
                    idx_n   = bit_idx + 1'b1;
                    shift   = 1'b1;
                    tmr_val = (idx_n == PAUSE_AT) ? HALF_M1 + tp_w : HALF_M1;
                end
            end
            PH_SETTLE: if (expire) begin
                ph_n     = PH_LATCH;
                tmr_load = 1'b1;
                tmr_val  = FULL_M1;
            end
            PH_LATCH: if (expire) begin
                if (!blk2) begin
                    ph_n     = PH_GAP;
                    blk2_n   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = HALF_M1 + tp_w;
                end else begin
                    ph_n = PH_IDLE;
                end
            end
            PH_GAP: if (expire) begin
                ph_n     = PH_LOW;
                idx_n    = '0;
                shift    = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = HALF_M1;
            end
            default: ph_n = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            bit_idx <= '0;
            blk2    <= 1'b0;
            rate_q  <= '0;
        end else begin
            phase   <= ph_n;
            bit_idx <= idx_n;
            blk2    <= blk2_n;
            rate_q  <= rate_n;
        end
    end

    // R4: bit counter stays inside one word
    a_r4_idx_in_word: assert property (@(posedge clk) disable iff (rst)
        bit_idx <= LAST_IDX);

    // R6: a latch pulse is always entered from the settle phase
    a_r6_latch_after_settle: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LATCH && $past(phase) != PH_LATCH) |-> $past(phase) == PH_SETTLE);

    // R8: the inter-word gap only follows the first latch pulse
    a_r8_gap_after_latch: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_GAP && $past(phase) != PH_GAP) |-> $past(phase) == PH_LATCH);

endmodule

// File: rtl/synth_loader.sv
module synth_loader
    import synth_loader_pkg::*;
#(
    parameter int HALF = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              power_on,
    input  logic              cfg_enable,
    input  logic [1:0]        rate_sel,
    input  logic [BLK_W-1:0]  blk_a,
    input  logic [BLK_W-1:0]  blk_b,
    output logic              ser_data,
    output logic              ser_clk,
    output logic              ser_latch,
    output logic              busy,
    output logic              osc_en
);
    localparam int MAXLEN = 2 * HALF + TP_MAX;
    localparam int CW     = $clog2(MAXLEN + 1);

    logic          pwr_q;
    logic          trigger;
    logic          capture, shift, tmr_load, expire, bit_out;
    logic [CW-1:0] tmr_val;
    phase_e        phase;

    always_ff @(posedge clk) begin
        if (rst) pwr_q <= 1'b0;
        else     pwr_q <= power_on;
    end

    assign trigger = power_on & ~pwr_q & cfg_enable;

    sl_seq_ctrl #(
        .BW(BLK_W), .PIDX(PAUSE_IDX), .HALF(HALF), .CW(CW)
    ) u_ctrl (
        .clk(clk), .rst(rst), .trigger(trigger), .rate(rate_sel),
        .expire(expire), .capture(capture), .shift(shift),
        .tmr_load(tmr_load), .tmr_val(tmr_val), .phase(phase)
    );

    sl_phase_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expire(expire)
    );

    sl_block_shifter #(.BW(BLK_W)) u_shift (
        .clk(clk), .rst(rst), .capture(capture), .shift(shift),
        .blk_a(blk_a), .blk_b(blk_b), .bit_out(bit_out)
    );

    assign busy      = (phase != PH_IDLE);
    assign osc_en    = busy;
    assign ser_clk   = (phase == PH_HIGH);
    assign ser_latch = (phase == PH_LATCH);
    assign ser_data  = busy & bit_out;

    // R5: data is steady while the shift clock is high
    a_r5_data_stable_high: assert property (@(posedge clk) disable iff (rst)
        (ser_clk && $past(ser_clk)) |-> ser_data == $past(ser_data));

    // R6: latch strobe never overlaps the shift clock
    a_r6_latch_clk_low: assert property (@(posedge clk) disable iff (rst)
        ser_latch |-> !ser_clk);

    // R2, R3: a transfer starts only from an enabled power-on edge
    a_r2_start_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(cfg_enable) && $past(power_on) && !$past(pwr_q)));

    // R1: link lines rest low while idle
    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!ser_clk && !ser_latch && !ser_data));

endmodule

// File: tb/synth_loader_test.sv
`timescale 1ns/1ps
module synth_loader_test;
    localparam int H = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        power_on = 1'b0;
    logic        cfg_enable = 1'b0;
    logic [1:0]  rate_sel = 2'd0;
    logic [23:0] blk_a = '0;
    logic [23:0] blk_b = '0;
    logic        ser_data, ser_clk, ser_latch, busy, osc_en;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    synth_loader #(.HALF(H)) uut (
        .clk(clk), .rst(rst), .power_on(power_on), .cfg_enable(cfg_enable),
        .rate_sel(rate_sel), .blk_a(blk_a), .blk_b(blk_b),
        .ser_data(ser_data), .ser_clk(ser_clk), .ser_latch(ser_latch),
        .busy(busy), .osc_en(osc_en)
    );

    // pin monitor, sampled on falling edges
    bit          mon_on = 1'b0;
    int          bitcnt, lowrun, highrun, highbad, chgbad, latchcnt, latchw;
    int          busycnt, oscbad;
    int          lowlen [48];
    int          prelow [2];
    int          latchwid [2];
    logic [47:0] cap;
    logic        p_clk, p_data, p_latch;

    task automatic mon_clear();
        bitcnt = 0; lowrun = 0; highrun = 0; highbad = 0; chgbad = 0;
        latchcnt = 0; latchw = 0; busycnt = 0; oscbad = 0; cap = '0;
        p_clk = 0; p_data = 0; p_latch = 0;
        for (int i = 0; i < 48; i++) lowlen[i] = -1;
        for (int i = 0; i < 2; i++) begin prelow[i] = -1; latchwid[i] = -1; end
        mon_on = 1'b1;
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            if (busy) busycnt++;
            if (osc_en !== busy) oscbad++;
            if (ser_clk && p_clk && ser_data !== p_data) chgbad++;
            if (ser_clk && !p_clk) begin
                if (bitcnt < 48) begin
                    cap[47 - bitcnt] = ser_data;
                    lowlen[bitcnt] = lowrun;
                end
                bitcnt++;
                lowrun = 0;
                highrun = 1;
            end else if (ser_clk) begin
                highrun++;
            end
            if (!ser_clk && p_clk && highrun != H) highbad++;
            if (ser_latch && !p_latch) begin
                if (latchcnt < 2) prelow[latchcnt] = lowrun;
                latchw = 1;
                lowrun = 0;
            end else if (ser_latch) begin
                latchw++;
            end
            if (!ser_latch && p_latch) begin
                if (latchcnt < 2) latchwid[latchcnt] = latchw;
                latchcnt++;
            end
            if (busy && !ser_clk && !ser_latch) lowrun++;
            p_clk = ser_clk; p_data = ser_data; p_latch = ser_latch;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_tp(input logic [1:0] r);
        return (r == 2'd0) ? 119 : (r == 2'd1) ? 33 : 1;
    endfunction

    task automatic run_xfer(input logic [1:0] r, input logic [23:0] a, input logic [23:0] b,
                            input bit poke);
        int tp = exp_tp(r);
        int lowbad = 0;
        @(posedge clk); #1;
        rate_sel = r; blk_a = a; blk_b = b; cfg_enable = 1'b1; power_on = 1'b0;
        @(posedge clk); #1;
        mon_clear();
        power_on = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R2 busy before sampling edge", busy, 0);
        @(negedge clk);
        chk(busy == 1'b1, "R2 busy after sampling edge", busy, 1);
        for (int k = 0; k < 2000 && busy; k++) begin
            @(negedge clk);
            if (poke && k == 50) begin
                blk_a = ~a; blk_b = ~b; rate_sel = ~r; power_on = 1'b0;
            end
            if (poke && k == 53) power_on = 1'b1;
        end
        repeat (20) @(negedge clk);
        chk(cap == {a, b}, poke ? "R11 words held during transfer" : "R4 bit order",
            cap, {a, b});
        chk(bitcnt == 48, "R4 bit count", bitcnt, 48);
        for (int i = 0; i < 48; i++) begin
            if (i != 12 && i != 24 && i != 36 && lowlen[i] != H) lowbad++;
        end
        chk(lowbad == 0 && highbad == 0, "R5 normal bit low/high time", lowbad + highbad, 0);
        chk(chgbad == 0, "R5 data change while clock high", chgbad, 0);
        chk(lowlen[12] == H + tp, "R7 pause in word 1", lowlen[12], H + tp);
        chk(lowlen[36] == H + tp, "R7 pause in word 2", lowlen[36], H + tp);
        chk(lowlen[24] == 2 * H + tp, "R8 inter-word gap", lowlen[24], 2 * H + tp);
        chk(latchcnt == 2, "R6 latch pulse count", latchcnt, 2);
        chk(latchwid[0] == 2 * H && latchwid[1] == 2 * H, "R6 latch width",
            latchwid[0] * 256 + latchwid[1], 2 * H * 257);
        chk(prelow[0] == H && prelow[1] == H, "R6 settle before latch",
            prelow[0] * 256 + prelow[1], H * 257);
        chk(busycnt == 103 * H + 3 * tp, poke ? "R10 retrigger ignored, busy length" :
            "R9 busy length", busycnt, 103 * H + 3 * tp);
        chk(oscbad == 0, "R9 osc_en follows busy", oscbad, 0);
        chk(busy == 1'b0, "R10 no restart with power held on", busy, 0);
        mon_on = 1'b0;
    endtask

    logic [23:0] pat_a [3];
    logic [23:0] pat_b [3];

    initial begin
        pat_a[0] = 24'h5A3C96; pat_b[0] = 24'h0F1E2D;
        pat_a[1] = 24'h000001; pat_b[1] = 24'h800000;
        pat_a[2] = 24'hFEDCBA; pat_b[2] = 24'h13579B;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk({ser_clk, ser_data, ser_latch, busy, osc_en} == 5'b0, "R1 reset outputs",
            {ser_clk, ser_data, ser_latch, busy, osc_en}, 0);

        // R3: disabled function ignores the power-on edge
        @(posedge clk); #1;
        cfg_enable = 1'b0; blk_a = 24'hFFFFFF; blk_b = 24'hFFFFFF;
        mon_clear();
        power_on = 1'b1;
        repeat (30) @(negedge clk);
        chk(busycnt == 0 && bitcnt == 0 && latchcnt == 0, "R3 disabled trigger",
            busycnt + bitcnt + latchcnt, 0);
        mon_on = 1'b0;
        @(posedge clk); #1 power_on = 1'b0;

        for (int r = 0; r < 4; r++) begin
            for (int p = 0; p < 3; p++) begin
                run_xfer(2'(r), pat_a[p], pat_b[p], p == 1);
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule